// File: doc/BRIEF.md
# Control Port Enable and Format Selector

This block decides, after each reset, whether the converter configures itself from strapped pins or is placed under software control. When reset is released it starts a stand-alone power-up sequence that counts rising edges of the audio frame clock. The frame clock is synchronised into the system clock domain before it is counted. When the sequence reaches its programmed length, a done flag is raised.

Software takes control by writing the control-enable bit, which reaches this block as a one-cycle write strobe. The first such write turns the control port on for good. It stops a sequence that is still running, and it sends one load-defaults pulse to the register file. If the write arrives after the sequence has already finished, a late-enable flag is also set.

The shared address / chip-select pin is synchronised and watched for falling edges. While the port is off, its activity is ignored, and the serial format stays I2C. Once the port is on, the first falling edge switches the format to SPI, and SPI stays selected until the next reset.

Top module: `ctl_port_arbiter`

## Requirements
- R1: While reset is asserted and on the first cycle after it, pwrup_done_o, ctl_active_o, spi_sel_o, load_defaults_o and late_en_o are all 0.
- R2: pwrup_done_o stays 0 until SEQ_LEN rising edges of frame_clk_i have been seen since reset, with no enable write before them. It rises at most SYNC_STAGES+2 clock cycles after the SEQ_LEN-th rising edge. It then stays 1 until reset, whatever further frame edges arrive.
- R3: An enable write made before the sequence completes halts the sequence. pwrup_done_o then stays 0 until reset, however many frame edges follow.
- R4: The first enable write (en_wr_i high at a clock edge) makes ctl_active_o 1 from the next cycle on, until reset.
- R5: load_defaults_o is a single-cycle pulse that coincides with the cycle ctl_active_o first reads 1. It occurs exactly once between resets; later enable writes produce no pulse.
- R6: late_en_o becomes 1 together with ctl_active_o when the activating write happens while pwrup_done_o is 1. Otherwise late_en_o stays 0.
- R7: While ctl_active_o is 1, a high-to-low transition of sel_pin_i makes spi_sel_o 1 within SYNC_STAGES+2 cycles. spi_sel_o 1 means SPI and 0 means I2C.
- R8: Transitions of sel_pin_i while ctl_active_o is 0, rising transitions, and a static level all leave spi_sel_o at 0 (I2C).
- R9: Once spi_sel_o is 1, it stays 1 regardless of sel_pin_i until reset returns it to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_clk_i | input | 1 | Audio frame clock, asynchronous to clk |
| en_wr_i | input | 1 | Strobe: control-enable bit written |
| sel_pin_i | input | 1 | Shared address / chip-select pin, asynchronous |
| pwrup_done_o | output | 1 | Stand-alone power-up sequence completed |
| ctl_active_o | output | 1 | Control port active |
| spi_sel_o | output | 1 | 1 = SPI format, 0 = I2C format |
| load_defaults_o | output | 1 | One-cycle pulse: load register defaults |
| late_en_o | output | 1 | Enable arrived after sequence completion |

## Verification
Each fault shows at the ports within a few cycles.

- A wrong sequence count shows as pwrup_done_o rising one frame edge early or late. Sweeping the enable write across every frame-edge count, including the lengths on either side of SEQ_LEN, exposes this directly.
- A halt state that fails to stick lets the done flag rise on a later frame edge, within SYNC_STAGES+2 cycles of that edge.
- A mode latch that is not sticky or not gated drops SPI, or picks it up, within SYNC_STAGES+2 cycles of a pin edge.
- A lost or repeated defaults pulse changes the pulse count seen on load_defaults_o.

// File: rtl/ctlarb_pkg.sv
package ctlarb_pkg;

    typedef enum logic [1:0] {
        SEQ_RUN  = 2'd0,
        SEQ_DONE = 2'd1,
        SEQ_HALT = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic active;
        logic load;
        logic late;
    } port_state_t;

endpackage

// File: rtl/ctlarb_edge_sync.sv
module ctlarb_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_t;

    sync_t sync_d, sync_q;
    logic [STAGES-1:0] shifted;

    assign shifted[0] = d_i;
    for (genvar g = 1; g < STAGES; g++) begin : g_chain
        assign shifted[g] = sync_q.chain[g-1];
    end

    always_comb begin
        sync_d       = sync_q;
        sync_d.chain = shifted;
        sync_d.prev  = sync_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign level_o = sync_q.chain[STAGES-1];
    assign rise_o  = level_o & ~sync_q.prev;
    assign fall_o  = ~level_o & sync_q.prev;

    // Edge pulses last one cycle
    assert_edge_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/ctlarb_pwrup_seq.sv
module ctlarb_pwrup_seq
    import ctlarb_pkg::*;
#(
    parameter  int SEQ_LEN = 1024,
    localparam int CNT_W   = $clog2(SEQ_LEN + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic halt_i,
    output logic done_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SEQ_LEN - 1);

    typedef struct packed {
        seq_state_e       st;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.st)
            SEQ_RUN: begin
                if (halt_i)
                    seq_d.st = SEQ_HALT;
                else if (tick_i && seq_q.cnt == LAST)
                    seq_d.st = SEQ_DONE;
                else if (tick_i)
                    seq_d.cnt = seq_q.cnt + 1'b1;
            end
            SEQ_DONE: seq_d.st = SEQ_DONE;
            SEQ_HALT: seq_d.st = SEQ_HALT;
            default:  seq_d.st = SEQ_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{st: SEQ_RUN, cnt: '0};
        else        seq_q <= seq_d;
    end

    assign done_o = (seq_q.st == SEQ_DONE);

    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.cnt < CNT_W'(SEQ_LEN));
    assert_done_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(tick_i));
    assert_halt_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == SEQ_HALT) |=> (seq_q.st == SEQ_HALT));
endmodule

// File: rtl/ctlarb_fmt_latch.sv
module ctlarb_fmt_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic fall_i,
    input  logic armed_i,
    output logic spi_o
);
    typedef struct packed {
        logic spi;
    } fmt_t;

    fmt_t fmt_d, fmt_q;

    always_comb begin
        fmt_d = fmt_q;
        if (armed_i && fall_i) fmt_d.spi = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fmt_q <= '0;
        else        fmt_q <= fmt_d;
    end

    assign spi_o = fmt_q.spi;

    assert_spi_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        spi_o |=> spi_o);
    assert_spi_needs_arm_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_o) |-> armed_i);
endmodule

// File: rtl/ctl_port_arbiter.sv
module ctl_port_arbiter
    import ctlarb_pkg::*;
#(
    parameter int SEQ_LEN     = 1024,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_clk_i,
    input  logic en_wr_i,
    input  logic sel_pin_i,
    output logic pwrup_done_o,
    output logic ctl_active_o,
    output logic spi_sel_o,
    output logic load_defaults_o,
    output logic late_en_o
);
    logic frame_lvl, frame_rise, frame_fall;
    logic pin_lvl, pin_rise, pin_fall;
    logic seq_done;

    port_state_t port_d, port_q;

    ctlarb_edge_sync #(.STAGES(SYNC_STAGES)) frame_sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_i     (frame_clk_i),
        .level_o (frame_lvl),
        .rise_o  (frame_rise),
        .fall_o  (frame_fall)
    );

    ctlarb_edge_sync #(.STAGES(SYNC_STAGES)) pin_sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_i     (sel_pin_i),
        .level_o (pin_lvl),
        .rise_o  (pin_rise),
        .fall_o  (pin_fall)
    );

    // A write in the same cycle as the final tick wins over completion
    ctlarb_pwrup_seq #(.SEQ_LEN(SEQ_LEN)) seq_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (frame_rise),
        .halt_i (port_q.active | en_wr_i),
        .done_o (seq_done)
    );

    ctlarb_fmt_latch fmt_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .fall_i  (pin_fall),
        .armed_i (port_q.active),
        .spi_o   (spi_sel_o)
    );

    always_comb begin
        port_d        = port_q;
        port_d.load   = en_wr_i & ~port_q.active;
        port_d.active = port_q.active | en_wr_i;
        port_d.late   = port_q.late | (en_wr_i & ~port_q.active & seq_done);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) port_q <= '0;
        else        port_q <= port_d;
    end

    assign pwrup_done_o    = seq_done;
    assign ctl_active_o    = port_q.active;
    assign load_defaults_o = port_q.load;
    assign late_en_o       = port_q.late;

    assert_active_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_active_o |=> ctl_active_o);
    assert_load_on_activate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_active_o) |-> load_defaults_o);
    assert_load_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load_defaults_o |=> !load_defaults_o);
    assert_late_needs_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        late_en_o |-> (pwrup_done_o && ctl_active_o));
    assert_halt_blocks_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_active_o && !pwrup_done_o) |=> !pwrup_done_o);
    assert_spi_only_active_R8: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sel_o |-> ctl_active_o);
endmodule

// File: tb/ctl_port_arbiter_tb.sv
module ctl_port_arbiter_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int SEQ_LEN    = 16;
    localparam int MAX_EDGES  = SEQ_LEN + 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_clk = 1'b0;
    logic en_wr = 1'b0;
    logic sel_pin = 1'b1;
    logic pwrup_done, ctl_active, spi_sel, load_defaults, late_en;

    int checks = 0;
    int fails  = 0;
    int load_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ctl_port_arbiter #(.SEQ_LEN(SEQ_LEN), .SYNC_STAGES(2)) dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .frame_clk_i     (frame_clk),
        .en_wr_i         (en_wr),
        .sel_pin_i       (sel_pin),
        .pwrup_done_o    (pwrup_done),
        .ctl_active_o    (ctl_active),
        .spi_sel_o       (spi_sel),
        .load_defaults_o (load_defaults),
        .late_en_o       (late_en)
    );

    always @(negedge clk) if (rst_n && load_defaults) load_cnt++;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_neg(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic frame_edges(input int n);
        for (int i = 0; i < n; i++) begin
            frame_clk = 1'b1; wait_neg(4);
            frame_clk = 1'b0; wait_neg(4);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; frame_clk = 1'b0; en_wr = 1'b0; sel_pin = 1'b1;
        wait_neg(3);
        load_cnt = 0;
        rst_n = 1'b1;
        wait_neg(1);
    endtask

    task automatic pulse_en();
        en_wr = 1'b1; wait_neg(1);
        en_wr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int k = 0; k <= MAX_EDGES; k++) begin
            bit exp_done;
            exp_done = (k >= SEQ_LEN);
            do_reset();
            // R1 reset state
            check({pwrup_done, ctl_active, spi_sel, load_defaults, late_en} == 5'b0,
                  "R1 outputs after reset",
                  {pwrup_done, ctl_active, spi_sel, load_defaults, late_en}, 0);
            // R8 pin activity before activation ignored
            sel_pin = 1'b0; wait_neg(6);
            sel_pin = 1'b1; wait_neg(6);
            check(spi_sel == 1'b0, "R8 fall before active", spi_sel, 0);
            frame_edges(k);
            check(pwrup_done == exp_done, "R2 done after k edges", pwrup_done, exp_done);
            pulse_en();
            check(ctl_active == 1'b1, "R4 active after write", ctl_active, 1);
            check(load_defaults == 1'b1, "R5 pulse on activation", load_defaults, 1);
            check(late_en == exp_done, "R6 late flag", late_en, exp_done);
            wait_neg(1);
            check(load_defaults == 1'b0, "R5 pulse width", load_defaults, 0);
            wait_neg(2);
            pulse_en(); wait_neg(3);
            frame_edges(MAX_EDGES - k + 2);
            check(pwrup_done == exp_done, "R3 R2 done after more edges", pwrup_done, exp_done);
            check(ctl_active == 1'b1, "R4 active held", ctl_active, 1);
            check(load_cnt == 1, "R5 pulse count", load_cnt, 1);
            check(late_en == exp_done, "R6 late held", late_en, exp_done);
            check(spi_sel == 1'b0, "R8 static pin keeps I2C", spi_sel, 0);
            sel_pin = 1'b0; wait_neg(4);
            check(spi_sel == 1'b1, "R7 fall selects SPI", spi_sel, 1);
            sel_pin = 1'b1; wait_neg(6);
            check(spi_sel == 1'b1, "R9 SPI held after rise", spi_sel, 1);
            sel_pin = 1'b0; wait_neg(6);
            sel_pin = 1'b1; wait_neg(6);
            check(spi_sel == 1'b1, "R9 SPI held after toggles", spi_sel, 1);
        end
        do_reset();
        check(spi_sel == 1'b0, "R9 reset clears SPI", spi_sel, 0);
        check(ctl_active == 1'b0, "R1 reset clears active", ctl_active, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule